// File: doc/BRIEF.md
# Ping-pong hit window capture

This block sits behind one discriminator of a time-over-threshold front end. On every system clock it takes a 16-bit word in which each bit reports the discriminator state during one sixteenth of the clock period. Bit 0 is the earliest slice. At 50 MHz each slice is 1.25 ns wide and one window covers 20 ns. The words that produce these slices come from a phase generator outside the block.

Two window memories take turns. On one edge the current word is written into one memory, and the word from the edge before is judged in the other memory. Capture therefore never pauses. A window in which at least one slice is set is placed in an eight-entry queue. The queue entry carries the value of a free-running 16-bit coarse counter taken on the capture edge. A window in which every slice is clear is discarded. A downstream reader drains the queue through a valid/ready port.

Top module: `hitwin_capture`

## Requirements
- R1: While `rst_n` is low, and directly after it goes low, `out_valid_o` and `ovf_o` are 0. A reset empties the queue, clears both window memories and the counter, and clears the overflow flag.
- R2: Each queue entry is 32 bits wide. Bits [15:0] hold the captured word unchanged, bit 0 being the earliest slice. Bits [31:16] hold the stamp.
- R3: A word with all 16 bits clear produces no queue entry.
- R4: A pulse that sets bits in two consecutive words produces two separate entries. They appear in capture order and their stamps differ by one.
- R5: The first two rising edges after `rst_n` rises are used for reset synchronisation, and words seen on those edges are ignored. The word sampled on the third edge is stamped 0x0000. Each later edge adds one to the stamp, and after 0xFFFF the stamp goes to 0x0000 with no flag.
- R6: A non-zero word sampled on edge k while the queue is empty is presented at the output port directly after edge k+1.
- R7: The queue holds 8 entries. A window that reaches the queue while 8 entries are held is dropped, even if a read happens on the same edge. The drop sets `ovf_o`, which stays set until reset. Entries already held are not changed by the drop.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output entry stays stable. An entry is removed on an edge where both are high, and entries leave in the order they were captured.
- R9: Capture has no gaps. A non-zero word on every edge, with the reader always ready, yields one entry per edge and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Reset, active low. It is applied asynchronously and released synchronously |
| slice_i | input | 16 | Fine-time slice word for the current clock period, bit 0 earliest |
| out_ready_i | input | 1 | Reader accepts the presented entry |
| out_valid_o | output | 1 | An entry is presented |
| out_data_o | output | 32 | Entry: stamp in [31:16], slice pattern in [15:0] |
| ovf_o | output | 1 | Sticky flag: a window was lost because the queue was full |

## Verification
The stamp is taken on the same edge that captures the word. The entry becomes visible one edge later, when the queue was empty. After reset release, the third edge is the first one that captures. The bench keeps a cycle model that is advanced on each rising edge using this timing and the fixed depth of eight. It drives inputs and compares every output on the falling edge, so each result is read half a period after the edge that produced it. A sweep through all 65536 words covers every slice pattern and also carries the stamp through its wrap. Directed phases cover the two-edge latency, paired windows, a full queue with a sticky drop, and irregular back-pressure.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  // Default geometry of one capture lane
  localparam int DEF_CELLS       = 16;
  localparam int DEF_STAMP_W     = 16;
  localparam int DEF_QUEUE_DEPTH = 8;
  localparam int DEF_SYNC_STAGES = 2;

  // Which of the two window memories is being written this cycle
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/hwc_rst_sync.sv
module hwc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hwc_coarse_ctr.sv
module hwc_coarse_ctr #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;

  // Wraps silently at the top of the range
  always_comb begin
    count_d = count_q;
    if (en_i) begin
      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/hwc_pingpong.sv
module hwc_pingpong
  import hwc_pkg::*;
#(
  parameter int CELLS   = 16,
  parameter int STAMP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CELLS-1:0]   cells_i,
  input  logic [STAMP_W-1:0] stamp_i,
  output logic [CELLS-1:0]   done_cells_o,
  output logic [STAMP_W-1:0] done_stamp_o,
  output logic               done_hit_o,
  output logic               wr_bank_o
);

  localparam int BANKS = 2;

  bank_e sel_q;
  bank_e sel_d;

  logic [BANKS-1:0][CELLS-1:0]   bank_cells;
  logic [BANKS-1:0][STAMP_W-1:0] bank_stamp;

  // Alternate every cycle: one bank fills while the other is judged
  always_comb begin
    sel_d = other_bank(sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= BANK_A;
    end else begin
      sel_q <= sel_d;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic               wr_en;
    logic [CELLS-1:0]   cells_q;
    logic [CELLS-1:0]   cells_d;
    logic [STAMP_W-1:0] stamp_q;
    logic [STAMP_W-1:0] stamp_d;

    always_comb begin
      wr_en   = (sel_q == bank_e'(b));
      cells_d = cells_q;
      stamp_d = stamp_q;
      if (wr_en) begin
        cells_d = cells_i;
        stamp_d = stamp_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells_q <= '0;
        stamp_q <= '0;
      end else begin
        cells_q <= cells_d;
        stamp_q <= stamp_d;
      end
    end

    assign bank_cells[b] = cells_q;
    assign bank_stamp[b] = stamp_q;
  end

  // The bank not being written holds the word from the previous edge
  logic rd_idx;
  assign rd_idx = sel_d;

  assign done_cells_o = bank_cells[rd_idx];
  assign done_stamp_o = bank_stamp[rd_idx];
  assign done_hit_o   = |done_cells_o;
  assign wr_bank_o    = sel_q;

endmodule

// File: rtl/hwc_fifo.sv
module hwc_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           push_data_i,
  input  logic                       pop_ready_i,
  output logic                       pop_valid_o,
  output logic [WIDTH-1:0]           pop_data_o,
  output logic                       ovf_o,
  output logic [$clog2(DEPTH):0]     level_o
);

  // DEPTH must be a power of two; pointers carry one wrap bit
  localparam int AW    = $clog2(DEPTH);
  localparam int PTR_W = AW + 1;

  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic             ovf_q, ovf_d;
  logic [PTR_W-1:0] level;
  logic             full;
  logic             accept;
  logic             take;

  logic [WIDTH-1:0] mem [DEPTH];

  always_comb begin
    level  = wr_q - rd_q;
    full   = (level == PTR_W'(DEPTH));
    accept = push_i && !full;
    take   = (level != '0) && pop_ready_i;

    wr_d  = wr_q;
    rd_d  = rd_q;
    ovf_d = ovf_q;
    if (accept) begin
      wr_d = wr_q + 1'b1;
    end
    if (take) begin
      rd_d = rd_q + 1'b1;
    end
    if (push_i && full) begin
      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      ovf_q <= ovf_d;
    end
  end

  // Storage array is not reset: pointers guard every read
  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wr_q[AW-1:0]] <= push_data_i;
    end
  end

  assign pop_valid_o = (level != '0);
  assign pop_data_o  = mem[rd_q[AW-1:0]];
  assign ovf_o       = ovf_q;
  assign level_o     = level;

endmodule

// File: rtl/hitwin_capture.sv
module hitwin_capture #(
  parameter int CELLS       = hwc_pkg::DEF_CELLS,
  parameter int STAMP_W     = hwc_pkg::DEF_STAMP_W,
  parameter int QUEUE_DEPTH = hwc_pkg::DEF_QUEUE_DEPTH,
  parameter int SYNC_STAGES = hwc_pkg::DEF_SYNC_STAGES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CELLS-1:0]           slice_i,
  input  logic                       out_ready_i,
  output logic                       out_valid_o,
  output logic [STAMP_W+CELLS-1:0]   out_data_o,
  output logic                       ovf_o
);

  localparam int ENTRY_W = STAMP_W + CELLS;
  localparam int LVL_W   = $clog2(QUEUE_DEPTH) + 1;

  logic               rst_int_n;
  logic [STAMP_W-1:0] stamp_now;
  logic [CELLS-1:0]   done_cells;
  logic [STAMP_W-1:0] done_stamp;
  logic               done_hit;
  logic               wr_bank;
  logic [LVL_W-1:0]   fifo_level;
  logic [ENTRY_W-1:0] push_entry;
  logic               ctr_en;

  hwc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_int_n)
  );

  assign ctr_en = 1'b1;

  hwc_coarse_ctr #(
    .WIDTH (STAMP_W)
  ) u_coarse (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (ctr_en),
    .count_o (stamp_now)
  );

  hwc_pingpong #(
    .CELLS   (CELLS),
    .STAMP_W (STAMP_W)
  ) u_pingpong (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cells_i      (slice_i),
    .stamp_i      (stamp_now),
    .done_cells_o (done_cells),
    .done_stamp_o (done_stamp),
    .done_hit_o   (done_hit),
    .wr_bank_o    (wr_bank)
  );

  assign push_entry = {done_stamp, done_cells};

  hwc_fifo #(
    .WIDTH (ENTRY_W),
    .DEPTH (QUEUE_DEPTH)
  ) u_fifo (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .push_i      (done_hit),
    .push_data_i (push_entry),
    .pop_ready_i (out_ready_i),
    .pop_valid_o (out_valid_o),
    .pop_data_o  (out_data_o),
    .ovf_o       (ovf_o),
    .level_o     (fifo_level)
  );

endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int CELLS       = 16,
  parameter int STAMP_W     = 16,
  parameter int QUEUE_DEPTH = 8
) (
  input logic                              clk,
  input logic                              rst_int_n,
  input logic [STAMP_W-1:0]                stamp_now,
  input logic                              done_hit,
  input logic                              wr_bank,
  input logic [$clog2(QUEUE_DEPTH):0]      fifo_level,
  input logic                              out_valid,
  input logic                              out_ready,
  input logic [STAMP_W+CELLS-1:0]          out_data,
  input logic                              ovf
);

  localparam int LVL_W = $clog2(QUEUE_DEPTH) + 1;

  // R1: reset leaves nothing presented and no overflow
  always @(negedge clk) begin
    if (!rst_int_n) begin
      p_reset_clear_r1: assert (!out_valid && !ovf)
        else $error("reset state not clear");
    end
  end

  p_stamp_step_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stamp_now != '1) |=> (stamp_now == $past(stamp_now) + 1'b1));

  p_stamp_wrap_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stamp_now == '1) |=> (stamp_now == '0));

  p_zero_drop_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!done_hit && !(out_valid && out_ready)) |=> $stable(fifo_level));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_hit && (fifo_level < LVL_W'(QUEUE_DEPTH)) && !(out_valid && out_ready))
      |=> (fifo_level == $past(fifo_level) + 1'b1));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovf |=> ovf);

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_hit && (fifo_level == LVL_W'(QUEUE_DEPTH))) |=> ovf);

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_level <= LVL_W'(QUEUE_DEPTH));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_bank_toggle_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n |=> (wr_bank != $past(wr_bank)));

endmodule

bind hitwin_capture hwc_checker #(
  .CELLS       (CELLS),
  .STAMP_W     (STAMP_W),
  .QUEUE_DEPTH (QUEUE_DEPTH)
) u_hwc_checker (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .stamp_now  (stamp_now),
  .done_hit   (done_hit),
  .wr_bank    (wr_bank),
  .fifo_level (fifo_level),
  .out_valid  (out_valid_o),
  .out_ready  (out_ready_i),
  .out_data   (out_data_o),
  .ovf        (ovf_o)
);

// File: tb/hitwin_capture_bench.sv
`timescale 1ns/1ps
module hitwin_capture_bench;

  localparam int DEPTH    = 8;
  localparam int WD_LIMIT = 150000;

  logic        clk;
  logic        rst_n;
  logic [15:0] slice;
  logic        out_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        ovf;

  int checks;
  int errors;
  bit done;
  string cur_req;

  hitwin_capture u_hitwin_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .slice_i     (slice),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .ovf_o       (ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- cycle model, advanced on each rising edge ----------------
  logic [31:0] mq [$];
  logic [31:0] pend;
  bit          pend_hit;
  logic [15:0] m_cnt;
  bit          m_ovf;
  bit          model_on;
  int          m_lvl;
  bit          m_pop;

  task automatic model_clear();
    mq.delete();
    pend     = '0;
    pend_hit = 1'b0;
    m_cnt    = '0;
    m_ovf    = 1'b0;
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      m_lvl = mq.size();
      m_pop = (m_lvl > 0) && out_ready;
      if (pend_hit && (m_lvl == DEPTH)) m_ovf = 1'b1;
      if (m_pop) void'(mq.pop_front());
      if (pend_hit && (m_lvl < DEPTH)) mq.push_back(pend);
      pend     = {m_cnt, slice};
      pend_hit = (slice != 16'h0);
      m_cnt    = m_cnt + 16'd1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Continuous comparison against the model, half a period after each edge
  always @(negedge clk) begin
    if (model_on && !done) begin
      chk(cur_req, "valid", {31'd0, out_valid}, {31'd0, (mq.size() > 0)});
      if (out_valid && (mq.size() > 0)) begin
        chk(cur_req, "entry", out_data, mq[0]);
      end
      chk("R7", "overflow flag", {31'd0, ovf}, {31'd0, m_ovf});
    end
  end

  // Drive one word for the next rising edge; returns on the following falling edge
  task automatic step(input logic [15:0] w, input logic rdy);
    slice     = w;
    out_ready = rdy;
    @(negedge clk);
  endtask

  task automatic do_reset();
    model_on  = 1'b0;
    slice     = '0;
    out_ready = 1'b0;
    rst_n     = 1'b0;
    model_clear();
    @(negedge clk);
    chk("R1", "valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1", "overflow in reset", {31'd0, ovf}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // words on the two synchronising edges are ignored (R5)
    slice = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    slice    = '0;
    model_on = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int pops;
    logic [15:0] s0;
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    model_on  = 1'b0;
    rst_n     = 1'b0;
    slice     = '0;
    out_ready = 1'b0;
    cur_req   = "R1";
    @(negedge clk);
    do_reset();

    // R6 latency and R5 first stamp after release
    cur_req = "R6";
    step(16'h8001, 1'b0);
    chk("R6", "valid one edge after capture", {31'd0, out_valid}, 32'd0);
    step(16'h0000, 1'b0);
    chk("R6", "valid two edges after capture", {31'd0, out_valid}, 32'd1);
    chk("R5", "first stamp and word", out_data, {16'h0000, 16'h8001});
    step(16'h0000, 1'b1);
    step(16'h0000, 1'b0);

    // R3 all-zero windows leave the queue empty
    cur_req = "R3";
    for (int i = 0; i < 20; i++) step(16'h0000, 1'b1);
    chk("R3", "no entry from zero words", {31'd0, out_valid}, 32'd0);

    // R4 pulse across two windows
    cur_req = "R4";
    s0 = m_cnt;
    step(16'hFC00, 1'b0);
    step(16'h003F, 1'b0);
    step(16'h0000, 1'b0);
    step(16'h0000, 1'b0);
    chk("R4", "first half", out_data, {s0, 16'hFC00});
    step(16'h0000, 1'b1);
    chk("R4", "second half", out_data, {s0 + 16'd1, 16'h003F});
    step(16'h0000, 1'b1);
    chk("R4", "queue empty after both", {31'd0, out_valid}, 32'd0);

    // R7 overflow with the reader stalled
    cur_req = "R7";
    for (int i = 0; i < 12; i++) step(16'(i + 1), 1'b0);
    step(16'h0000, 1'b0);
    step(16'h0000, 1'b0);
    chk("R7", "overflow set", {31'd0, ovf}, 32'd1);
    chk("R7", "oldest kept", {16'd0, out_data[15:0]}, 32'd1);
    pops = 0;
    for (int i = 0; i < 12; i++) begin
      if (out_valid) pops++;
      step(16'h0000, 1'b1);
    end
    chk("R7", "entries held", pops, DEPTH);
    chk("R7", "overflow sticky", {31'd0, ovf}, 32'd1);

    // R1 reset clears the sticky flag and the queue
    cur_req = "R1";
    do_reset();
    chk("R1", "valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1", "overflow after reset", {31'd0, ovf}, 32'd0);

    // R2, R5, R9 every word value on consecutive edges, stamp wraps
    cur_req = "R2";
    for (int v = 0; v < 65536; v++) step(16'(v), 1'b1);
    cur_req = "R5";
    for (int i = 0; i < 24; i++) step(16'h0001, 1'b1);
    cur_req = "R9";
    for (int i = 0; i < 4; i++) step(16'h0000, 1'b1);
    chk("R9", "all drained", {31'd0, out_valid}, 32'd0);
    chk("R9", "nothing lost", {31'd0, ovf}, 32'd0);

    // R8 irregular reader and writer
    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      step(((i % 3) != 0) ? 16'(16'h0100 | i) : 16'h0000, ((i % 4) != 0));
    end
    for (int i = 0; i < 12; i++) step(16'h0000, 1'b1);
    chk("R8", "drained", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule